// File: doc/BRIEF.md
# Minibatch Gradient-Descent Linear Trainer

This block trains a 16-weight linear model on a stream of samples. Every cycle it can take one line of 16 signed Q16.16 features plus a Q16.16 label. The line is multiplied lane by lane with the current weights, and a pipelined tree of saturating adders reduces the 16 products to a prediction. While the prediction moves through the tree, the features and the label wait in two small FIFOs. When the prediction comes out, the block subtracts the label and scales the difference by the configured step size. It then multiplies that error by each feature to form a 16-lane gradient and adds the gradient into per-lane accumulators.

A small batch controller has two states. In `BATCH_EMPTY` no gradient is held. `BATCH_PARTIAL` means that part of a minibatch has been summed. There are three transitions. `EMPTY->PARTIAL` happens on a gradient that does not finish the batch. `PARTIAL->EMPTY` happens on the gradient that does finish it, which is a commit. `EMPTY->EMPTY` with a commit happens when a single gradient makes up the whole batch. On a commit, every weight has its accumulated gradient subtracted from it and the accumulators start again from zero. The weights are visible at all times on a flat readout bus.

The input never applies back-pressure. A sample is accepted in every cycle in which it is offered. A sample that enters while an earlier batch is still in flight uses the weights that are in place when it enters.

Top module: `sgd_trainer`

## Requirements
- R1: While reset is held and in the first cycle after it, all 16 weights on `model_out` read zero and no partial batch is held. `in_ready` is low during reset and high from the first clock edge after reset.
- R2: Once out of reset, `in_ready` stays high, and a line offered on every cycle is accepted on every cycle. The internal feature and label FIFOs never overflow and never underflow.
- R3: All arithmetic is signed Q16.16 with 16 fractional bits. A product is the full 64-bit product shifted right arithmetically by 16 (rounding toward minus infinity), then clamped to [-2^31, 2^31-1]. Every sum and difference is also clamped to that range.
- R4: The prediction uses the saturated per-lane products p0..p15. It is reduced in four levels of pairwise saturating adds, in which node j of each level adds elements 2j and 2j+1 of the level below.
- R5: The error is step*(prediction - label). The step value is read when the prediction leaves the tree. The lane-i gradient is error*feature_i, and it is added with saturation into accumulator i.
- R6: When the number of gradients summed reaches `batch_size`, each weight i becomes weight_i - acc_i with saturation, where acc_i includes the last gradient. The accumulators and the count are then cleared and the next gradient starts a new batch.
- R7: A commit becomes visible on `model_out` at the 7th rising edge after the edge that accepted the last sample of the batch. A sample accepted at or before that edge is computed with the weights from before the commit.
- R8: A `batch_size` of 0 behaves exactly like 1, so every sample commits.
- R9: `model_out` holds its value on every edge that is not a commit edge.
- R10: Starting from zero weights with step 1.0, a sample whose features are all 2.0 and whose label is -32768.0 saturates each weight to 0x80000001. A second identical sample then leaves the weights unchanged, because its prediction saturates to the label.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample line is offered |
| in_ready | output | 1 | Sample accepted when high together with in_valid |
| in_features | input | LANES*32 | Lane i in bits [32i+31:32i], Q16.16 |
| in_label | input | 32 | Target value of the sample, Q16.16 |
| step_size | input | 32 | Learning rate, Q16.16 |
| batch_size | input | BATCH_W | Gradients per commit, 0 treated as 1 |
| model_out | output | LANES*32 | Current weights, lane i in bits [32i+31:32i] |

## Verification
The bench builds the block with its default parameters: 16 lanes, so the tree has four levels and commits land seven edges after the last accept, plus an 8-entry FIFO and an 8-bit batch size. With these values it can run back-to-back streams at batch sizes 4, 3, 1 and 0, with and without gaps. At batch size 1 under full rate, later samples enter before earlier commits land, which exercises the stale-weight rule. A second reset followed by extreme values drives every clamp point of the Q16.16 datapath.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
    localparam int DATA_W = 32;
    localparam int FRAC_W = 16;

    typedef logic signed [DATA_W-1:0]   q_t;
    typedef logic signed [2*DATA_W-1:0] wide_t;

    typedef enum logic [0:0] {
        BATCH_EMPTY   = 1'b0,
        BATCH_PARTIAL = 1'b1
    } batch_state_t;

    localparam wide_t Q_HI = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam wide_t Q_LO = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    function automatic q_t q_clip(input wide_t v);
        if (v > Q_HI)
            return {1'b0, {(DATA_W-1){1'b1}}};
        else if (v < Q_LO)
            return {1'b1, {(DATA_W-1){1'b0}}};
        else
            return v[DATA_W-1:0];
    endfunction

    function automatic q_t q_add(input q_t a, input q_t b);
        return q_clip(wide_t'(a) + wide_t'(b));
    endfunction

    function automatic q_t q_sub(input q_t a, input q_t b);
        return q_clip(wide_t'(a) - wide_t'(b));
    endfunction

    function automatic q_t q_mul(input q_t a, input q_t b);
        wide_t p;
        p = wide_t'(a) * wide_t'(b);
        return q_clip(p >>> FRAC_W);
    endfunction
endpackage

// File: rtl/sgd_fifo.sv
module sgd_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign dout = mem[rd_ptr];

    // R2: a full-rate stream must never find the FIFO full
    a_r2_fifo_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CW'(DEPTH)));

    // R2: a pop is only requested when an entry is waiting
    a_r2_fifo_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/sgd_dot.sv
module sgd_dot #(
    parameter int LANES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v,
    input  sgd_pkg::q_t   feat  [LANES],
    input  sgd_pkg::q_t   model [LANES],
    output logic          dot_v,
    output sgd_pkg::q_t   dot
);
    import sgd_pkg::*;

    localparam int LEVELS = $clog2(LANES);

    q_t   node [LEVELS+1][LANES];
    logic v_pipe [LEVELS+1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l <= LEVELS; l++) begin
                v_pipe[l] <= 1'b0;
                for (int j = 0; j < LANES; j++) node[l][j] <= '0;
            end
        end else begin
            v_pipe[0] <= in_v;
            for (int j = 0; j < LANES; j++)
                node[0][j] <= q_mul(feat[j], model[j]);
            for (int l = 1; l <= LEVELS; l++) begin
                v_pipe[l] <= v_pipe[l-1];
                for (int j = 0; j < LANES; j++) begin
                    if (j < (LANES >> l))
                        node[l][j] <= q_add(node[l-1][2*j], node[l-1][2*j+1]);
                    else
                        node[l][j] <= '0;
                end
            end
        end
    end

    assign dot_v = v_pipe[LEVELS];
    assign dot   = node[LEVELS][0];
endmodule

// File: rtl/sgd_update.sv
module sgd_update #(
    parameter int LANES   = 16,
    parameter int BATCH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dot_v,
    input  sgd_pkg::q_t        dot,
    input  sgd_pkg::q_t        label,
    input  sgd_pkg::q_t        feat  [LANES],
    input  sgd_pkg::q_t        step,
    input  logic [BATCH_W-1:0] batch_size,
    output sgd_pkg::q_t        model [LANES]
);
    import sgd_pkg::*;

    localparam int CNT_W = BATCH_W + 1;

    // error stage
    logic err_v;
    q_t   err_q;
    q_t   a_q [LANES];
    // gradient stage
    logic grad_v;
    q_t   grad_q [LANES];
    // batch state
    batch_state_t     st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] eff_batch;
    logic             last;
    logic             commit;
    q_t               acc [LANES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_v  <= 1'b0;
            grad_v <= 1'b0;
            err_q  <= '0;
            for (int i = 0; i < LANES; i++) begin
                a_q[i]    <= '0;
                grad_q[i] <= '0;
            end
        end else begin
            err_v  <= dot_v;
            grad_v <= err_v;
            if (dot_v) begin
                err_q <= q_mul(step, q_sub(dot, label));
                for (int i = 0; i < LANES; i++) a_q[i] <= feat[i];
            end
            if (err_v) begin
                for (int i = 0; i < LANES; i++) grad_q[i] <= q_mul(err_q, a_q[i]);
            end
        end
    end

    assign eff_batch = (batch_size == '0) ? CNT_W'(1) : {1'b0, batch_size};
    assign last      = ((cnt + CNT_W'(1)) >= eff_batch);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= BATCH_EMPTY;
        else        st <= st_nx;
    end

    // next state and commit decision
    always_comb begin
        st_nx  = st;
        commit = 1'b0;
        unique case (st)
            BATCH_EMPTY: begin
                if (grad_v) begin
                    if (last) commit = 1'b1;
                    else      st_nx  = BATCH_PARTIAL;
                end
            end
            BATCH_PARTIAL: begin
                if (grad_v && last) begin
                    commit = 1'b1;
                    st_nx  = BATCH_EMPTY;
                end
            end
            default: st_nx = BATCH_EMPTY;
        endcase
    end

    // accumulators, count and weights
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < LANES; i++) begin
                acc[i]   <= '0;
                model[i] <= '0;
            end
        end else if (grad_v) begin
            if (commit) begin
                cnt <= '0;
                for (int i = 0; i < LANES; i++) begin
                    acc[i]   <= '0;
                    model[i] <= q_sub(model[i], q_add(acc[i], grad_q[i]));
                end
            end else begin
                cnt <= cnt + CNT_W'(1);
                for (int i = 0; i < LANES; i++) acc[i] <= q_add(acc[i], grad_q[i]);
            end
        end
    end

    // R6: a commit always leaves the controller with no partial batch
    a_r6_empty_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st == BATCH_EMPTY));

    // R6: an empty batch holds no counted gradients
    a_r6_empty_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BATCH_EMPTY) |-> (cnt == '0));

    // R5: a gradient only appears two edges after a prediction
    a_r5_grad_follows_dot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grad_v) |-> $past(dot_v, 2));

    for (genvar gi = 0; gi < LANES; gi++) begin : g_hold
        // R9: weights move only on a commit edge
        a_r9_model_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !commit |=> $stable(model[gi]));
    end
endmodule

// File: rtl/sgd_trainer.sv
module sgd_trainer #(
    parameter int LANES      = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int BATCH_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*32-1:0]    in_features,
    input  logic [31:0]            in_label,
    input  logic [31:0]            step_size,
    input  logic [BATCH_W-1:0]     batch_size,
    output logic [LANES*32-1:0]    model_out
);
    import sgd_pkg::*;

    localparam int W        = DATA_W;
    localparam int LINE_W   = LANES * W;
    localparam int PIPE_OCC = $clog2(LANES) + 1;

    logic        ready_q;
    logic        accept;
    logic        dot_v;
    q_t          dot;
    q_t          feat_in   [LANES];
    q_t          feat_head [LANES];
    q_t          model     [LANES];
    logic [LINE_W-1:0] feat_head_flat;
    logic [W-1:0]      label_head;

    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    assign in_ready = ready_q;
    assign accept   = in_valid && ready_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign feat_in[i]          = in_features[i*W +: W];
        assign feat_head[i]        = feat_head_flat[i*W +: W];
        assign model_out[i*W +: W] = model[i];
    end

    sgd_fifo #(.WIDTH(LINE_W), .DEPTH(FIFO_DEPTH)) u_feat_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (accept),
        .din  (in_features),
        .pop  (dot_v),
        .dout (feat_head_flat)
    );

    sgd_fifo #(.WIDTH(W), .DEPTH(FIFO_DEPTH)) u_label_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (accept),
        .din  (in_label),
        .pop  (dot_v),
        .dout (label_head)
    );

    sgd_dot #(.LANES(LANES)) u_dot (
        .clk  (clk),
        .rst_n(rst_n),
        .in_v (accept),
        .feat (feat_in),
        .model(model),
        .dot_v(dot_v),
        .dot  (dot)
    );

    sgd_update #(.LANES(LANES), .BATCH_W(BATCH_W)) u_update (
        .clk       (clk),
        .rst_n     (rst_n),
        .dot_v     (dot_v),
        .dot       (dot),
        .label     (label_head),
        .feat      (feat_head),
        .step      (step_size),
        .batch_size(batch_size),
        .model     (model)
    );

    // R2: the FIFOs must hold every sample in flight at full rate
    a_r2_depth_covers_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (FIFO_DEPTH >= PIPE_OCC));

    // R1: ready only rises after reset has been released
    a_r1_ready_after_reset: assert property (@(posedge clk)
        !rst_n |=> !in_ready);
endmodule

// File: tb/sgd_trainer_bench.sv
module sgd_trainer_bench;
    localparam int LANES      = 16;
    localparam int W          = 32;
    localparam int BW         = 8;
    localparam int COMMIT_LAT = 7;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [LANES*W-1:0]  in_features = '0;
    logic [W-1:0]        in_label = '0;
    logic [W-1:0]        step_size = '0;
    logic [BW-1:0]       batch_size = 8'd1;
    logic [LANES*W-1:0]  model_out;

    always #5 clk = ~clk;

    sgd_trainer #(.LANES(LANES), .FIFO_DEPTH(8), .BATCH_W(BW)) u_sgd_trainer (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_features(in_features),
        .in_label   (in_label),
        .step_size  (step_size),
        .batch_size (batch_size),
        .model_out  (model_out)
    );

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        longint             edge_no;
        logic [LANES*W-1:0] m;
    } snap_t;

    snap_t score_q[$];
    snap_t apply_q[$];
    int    ref_seen   [LANES];
    int    ref_latest [LANES];
    int    ref_acc    [LANES];
    int    ref_cnt;
    logic [LANES*W-1:0] prev_model = '0;

    function automatic int clip(input longint v);
        if (v > 64'sd2147483647)  return 32'h7FFF_FFFF;
        if (v < -64'sd2147483648) return 32'h8000_0000;
        return int'(v);
    endfunction
    function automatic int sadd(input int a, input int b);
        return clip(longint'(a) + longint'(b));
    endfunction
    function automatic int ssub(input int a, input int b);
        return clip(longint'(a) - longint'(b));
    endfunction
    function automatic int smul(input int a, input int b);
        longint p;
        p = longint'(a) * longint'(b);
        return clip(p >>> 16);
    endfunction

    function automatic logic [LANES*W-1:0] pack_latest();
        logic [LANES*W-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*W +: W] = ref_latest[i];
        return v;
    endfunction

    task automatic check_vec(input string req, input logic [LANES*W-1:0] act,
                             input logic [LANES*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at edge %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at edge %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    task automatic ref_clear();
        for (int i = 0; i < LANES; i++) begin
            ref_seen[i] = 0; ref_latest[i] = 0; ref_acc[i] = 0;
        end
        ref_cnt = 0;
        score_q.delete();
        apply_q.delete();
        prev_model = '0;
    endtask

    // driver: offers one sample and pushes the expected commit onto the scoreboard
    task automatic send(input int f [LANES], input int lbl);
        longint t;
        int     p [LANES];
        int     n, diff, err, eff;
        snap_t  s;
        @(negedge clk);
        check_bit("R2 ready while streaming", in_ready, 1'b1);
        t = cyc + 1;
        while (apply_q.size() > 0 && apply_q[0].edge_no < t) begin
            for (int i = 0; i < LANES; i++) ref_seen[i] = apply_q[0].m[i*W +: W];
            void'(apply_q.pop_front());
        end
        in_valid = 1'b1;
        for (int i = 0; i < LANES; i++) in_features[i*W +: W] = f[i];
        in_label = lbl;
        // R3 R4: saturated products, pairwise saturating reduction
        for (int i = 0; i < LANES; i++) p[i] = smul(f[i], ref_seen[i]);
        n = LANES;
        while (n > 1) begin
            for (int j = 0; j < n / 2; j++) p[j] = sadd(p[2*j], p[2*j+1]);
            n = n / 2;
        end
        // R5: error and gradient accumulation
        diff = ssub(p[0], lbl);
        err  = smul(int'(step_size), diff);
        for (int i = 0; i < LANES; i++) ref_acc[i] = sadd(ref_acc[i], smul(err, f[i]));
        ref_cnt++;
        eff = (batch_size == 0) ? 1 : int'(batch_size);   // R8
        if (ref_cnt >= eff) begin
            for (int i = 0; i < LANES; i++) begin
                ref_latest[i] = ssub(ref_latest[i], ref_acc[i]);   // R6
                ref_acc[i] = 0;
            end
            ref_cnt   = 0;
            s.edge_no = t + COMMIT_LAT;                            // R7
            s.m       = pack_latest();
            score_q.push_back(s);
            apply_q.push_back(s);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_random(input int span_f, input int span_l);
        int f [LANES];
        int lbl;
        for (int i = 0; i < LANES; i++) f[i] = int'($urandom_range(0, 2*span_f)) - span_f;
        lbl = int'($urandom_range(0, 2*span_l)) - span_l;
        send(f, lbl);
    endtask

    // monitor: pops expected weights when their commit edge has passed
    always @(negedge clk) begin
        if (rst_n && score_q.size() > 0 && score_q[0].edge_no == cyc) begin
            check_vec("R6 weights after commit", model_out, score_q[0].m);
            prev_model = score_q[0].m;
            void'(score_q.pop_front());
        end
        if (rst_n && score_q.size() > 0 && score_q[0].edge_no == cyc + 1)
            check_vec("R7 R9 weights one edge before commit", model_out, prev_model);
    end

    always @(posedge clk) begin
        if (!done && cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual %0d cycles expected under 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int fs [LANES];
        ref_clear();
        repeat (3) @(negedge clk);
        check_bit("R1 ready low in reset", in_ready, 1'b0);
        check_vec("R1 weights zero in reset", model_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 ready high after reset", in_ready, 1'b1);
        check_vec("R1 weights zero after reset", model_out, '0);

        // batch 4, full rate
        step_size = 32'h0000_4000;
        batch_size = 8'd4;
        for (int k = 0; k < 12; k++) send_random(131072, 262144);
        idle(20);
        checks++;
        if (score_q.size() != 0) begin
            errors++;
            $display("FAIL R6 pending commits: actual %0d expected 0", score_q.size());
        end

        // batch 3 with gaps between samples
        step_size = 32'h0000_8000;
        batch_size = 8'd3;
        for (int k = 0; k < 9; k++) begin
            send_random(65536, 131072);
            idle(1);
        end
        idle(20);

        // batch 1 at full rate: later samples see stale weights (R7)
        step_size = 32'h0000_2000;
        batch_size = 8'd1;
        for (int k = 0; k < 10; k++) send_random(131072, 131072);
        idle(20);

        // batch 0 behaves as batch 1 (R8)
        batch_size = 8'd0;
        for (int k = 0; k < 3; k++) send_random(65536, 65536);
        idle(20);
        check_vec("R8 R9 weights after batch-zero run", model_out, pack_latest());

        // second reset, then saturation corner (R10)
        @(negedge clk);
        rst_n = 1'b0;
        ref_clear();
        idle(3);
        check_vec("R1 weights cleared by reset", model_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        step_size  = 32'h0001_0000;
        batch_size = 8'd1;
        for (int i = 0; i < LANES; i++) fs[i] = 32'h0002_0000;
        send(fs, 32'h8000_0000);
        idle(12);
        check_vec("R10 R3 weights saturated", model_out, {LANES{32'h8000_0001}});
        send(fs, 32'h8000_0000);
        idle(12);
        check_vec("R10 second sample leaves weights", model_out, {LANES{32'h8000_0001}});
        check_vec("R10 reference agreement", model_out, pack_latest());

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule